// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Control Model

This block is a clocked, synthesizable behavioural model of the control side of a one-time-programmable byte-wide memory. A device programmer or a bus host can run against it as if it were the real part. Each cycle it reads active-low chip select, output gate and program strobe, plus the address. It also reads two level flags: one says the high programming supply is present, the other says the high identification voltage is on address bit 9. From these it works out the operating mode. It then drives or releases the data bus, and it reports the mode it decoded.

The storage starts fully erased, so every bit reads as one. A program operation can only clear bits: the stored byte becomes the old byte ANDed with the data on the bus. The write is committed on the clock edge that first sees the program strobe back high after a program pulse. In identification mode the block returns fixed bytes instead of array contents. These are a manufacturer byte, a device byte and a continuation byte, and each has odd parity with bit 7 as the parity bit.

The data bus is split into an input, an output and an output-enable. A pad ring or a bench builds the tri-state from these three signals. The array depth is set by the address width parameter, and the default is kept small for simulation.

Top module: `otp_mem_model`

## Requirements
- R1: With the programming supply flag low, the ID flag low, and chip select and output gate both low, the block drives `dq_oe`=1 and puts the stored byte at `addr` on `dq_out`, whatever the program strobe is. `mode` is 2 (READ).
- R2: With chip select low, output gate high and the programming supply flag low, `dq_oe` is 0 and `mode` is 1 (DISABLE).
- R3: With chip select high, `dq_oe` is 0 whatever the output gate is. `mode` is 0 (STANDBY) when the supply flag is low and 5 (INHIBIT) when it is high. No byte is written, even if a full strobe pulse occurs.
- R4: With the supply flag high, chip select low, output gate high and strobe low, `mode` is 3 (PROGRAM) and `dq_oe` is 0. On the first clock edge that sees the strobe high again, with chip select still low, output gate high and supply high, the byte at `addr` becomes its old value ANDed with `dq_in`.
- R5: With the supply flag high, chip select and output gate low, and strobe high, `mode` is 4 (VERIFY) and the stored byte at `addr` is driven.
- R6: With the ID flag high, the supply flag low, chip select and output gate low, and `addr[1]`=1, `mode` is 6 (ID). `dq_out` is 0x1C when `addr[0]`=0 and 0x01 when `addr[0]`=1.
- R7: In identification mode with `addr[1]`=0, `dq_out` is 0x7F for either value of `addr[0]`.
- R8: Every byte driven in identification mode has an odd number of ones, with bit 7 as the parity bit.
- R9: After reset, every byte that has not been programmed reads 0xFF.
- R10: Repeated programming of one byte never turns a 0 bit back to 1. The result is the AND of all the data written to that byte.
- R11: Pin combinations that match no defined mode decode to 1 (DISABLE) with `dq_oe`=0. One is supply high with chip select, output gate and strobe all low. Another is supply high with chip select low and both output gate and strobe high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; marks every byte erased |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low program strobe |
| addr | input | ADDR_W | Byte address (bits 1 and 0 also pick the ID byte) |
| vpp_hi | input | 1 | High programming supply present |
| id_hv | input | 1 | High identification voltage present on address bit 9 |
| dq_in | input | 8 | Data bus as seen by the block (program data) |
| dq_out | output | 8 | Data the block drives |
| dq_oe | output | 1 | 1 when the block drives the data bus |
| mode | output | 3 | Decoded mode: 0 STANDBY, 1 DISABLE, 2 READ, 3 PROGRAM, 4 VERIFY, 5 INHIBIT, 6 ID |

## Verification
The assertions watch bus release on every cycle, in two cases: whenever chip select or the output gate is high, and the driven state under a plain read. They also check the odd parity of every identification byte, and that a committed program never sets a bit that was clear. The bench scenarios are needed for the sequential parts. These are the one-cycle-late commit after the strobe returns high, the AND accumulation over several pulses, the inhibit case where a full pulse leaves the byte erased, and the exact identification byte chosen by the two low address bits.

// File: rtl/otp_mem_model.sv
module otp_mem_model #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic [2:0]        mode
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {
    M_STANDBY = 3'd0, M_DISABLE = 3'd1, M_READ = 3'd2, M_PROGRAM = 3'd3,
    M_VERIFY  = 3'd4, M_INHIBIT = 3'd5, M_ID   = 3'd6
  } mode_e;

  mode_e            cur;
  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] used;
  logic             prog_q;
  logic [7:0]       arr_byte, id_byte;
  logic             commit;

  always_comb begin
    if (ce_n)             cur = vpp_hi ? M_INHIBIT : M_STANDBY;
    else if (vpp_hi) begin
      if (oe_n)           cur = pgm_n ? M_DISABLE : M_PROGRAM;
      else                cur = pgm_n ? M_VERIFY  : M_DISABLE;
    end
    else if (oe_n)        cur = M_DISABLE;
    else if (id_hv)       cur = M_ID;
    else                  cur = M_READ;
  end

  assign arr_byte = used[addr] ? mem[addr] : 8'hFF;
  assign id_byte  = !addr[1] ? 8'h7F : (addr[0] ? 8'h01 : 8'h1C);
  assign commit   = prog_q && pgm_n && !ce_n && oe_n && vpp_hi;

  assign mode   = cur;
  assign dq_oe  = (cur == M_READ) || (cur == M_VERIFY) || (cur == M_ID);
  assign dq_out = (cur == M_ID) ? id_byte : (dq_oe ? arr_byte : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0;
      used   <= '0;
    end else begin
      prog_q <= (cur == M_PROGRAM);
      if (commit) used[addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[addr] <= arr_byte & dq_in;
  end

  // R3
  standby_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dq_oe);

  // R2
  gate_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  // R1
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi) |-> dq_oe);

  // R8
  id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi && id_hv) |-> ($countones(dq_out) % 2 == 1));

  // R10
  no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!$stable(addr) || ((arr_byte & ~$past(arr_byte)) == 8'h00)));
endmodule

// File: tb/otp_mem_model_tb.sv
`timescale 1ns/1ps
module otp_mem_model_tb;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, id_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dq_in = 8'h00;
  logic [7:0]    dq_out;
  logic          dq_oe;
  logic [2:0]    mode;

  always #2 clk = ~clk;

  otp_mem_model #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .addr(addr), .vpp_hi(vpp_hi), .id_hv(id_hv), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .mode(mode)
  );

  typedef struct {
    logic       oe;
    logic [7:0] data;
    logic [2:0] md;
    logic       parity;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   total = 0, fails = 0;
  bit   done = 1'b0;
  logic [7:0] model [int];

  function automatic logic [7:0] stored(int a);
    return model.exists(a) ? model[a] : 8'hFF;
  endfunction

  task automatic step(input logic c, o, p, v, i, input int a, input logic [7:0] d,
                      input logic eo, input logic [7:0] ed, input logic [2:0] em,
                      input logic par, input string tag);
    exp_t e;
    @(posedge clk); #1;
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; id_hv = i; addr = AW'(a); dq_in = d;
    e.oe = eo; e.data = ed; e.md = em; e.parity = par; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (dq_oe !== e.oe || mode !== e.md || (e.oe && dq_out !== e.data)) begin
        fails++;
        $display("FAIL %s: oe=%0b mode=%0d data=%02h, expected oe=%0b mode=%0d data=%02h",
                 e.tag, dq_oe, mode, dq_out, e.oe, e.md, e.data);
      end
      if (e.parity) begin
        total++;
        if ($countones(dq_out) % 2 != 1) begin
          fails++;
          $display("FAIL R8: data=%02h has even parity, expected odd", dq_out);
        end
      end
    end
  end

  task automatic prog(input int a, input logic [7:0] d);
    step(0, 1, 0, 1, 0, a, d, 0, 8'h00, 3'd3, 0, "R4 program pulse");
    step(0, 1, 1, 1, 0, a, d, 0, 8'h00, 3'd1, 0, "R11 strobe high oe high");
    model[a] = stored(a) & d;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(1, 0, 1, 0, 0, 5, 8'h00, 0, 8'h00, 3'd0, 0, "R3 standby oe low");
    step(0, 0, 1, 0, 0, 5, 8'h00, 1, 8'hFF, 3'd2, 0, "R9 erased read");
    step(0, 0, 1, 0, 0, 1023, 8'h00, 1, 8'hFF, 3'd2, 0, "R9 erased top byte");
    prog(5, 8'hA5);
    step(0, 0, 1, 1, 0, 5, 8'h00, 1, stored(5), 3'd4, 0, "R5 verify");
    step(0, 0, 0, 0, 0, 5, 8'h00, 1, stored(5), 3'd2, 0, "R1 read strobe low");
    prog(5, 8'h5A);
    step(0, 0, 1, 1, 0, 5, 8'h00, 1, 8'h00, 3'd4, 0, "R10 and to zero");
    prog(7, 8'hF0);
    prog(7, 8'hFF);
    step(0, 0, 1, 1, 0, 7, 8'h00, 1, 8'hF0, 3'd4, 0, "R10 no bit back to one");
    prog(7, 8'h3C);
    step(0, 0, 1, 0, 0, 7, 8'h00, 1, stored(7), 3'd2, 0, "R10 accumulated and");
    step(1, 1, 0, 1, 0, 9, 8'h00, 0, 8'h00, 3'd5, 0, "R3 inhibit pulse");
    step(1, 1, 1, 1, 0, 9, 8'h00, 0, 8'h00, 3'd5, 0, "R3 inhibit strobe high");
    step(0, 0, 1, 0, 0, 9, 8'h00, 1, 8'hFF, 3'd2, 0, "R3 inhibited byte unchanged");
    step(0, 1, 1, 0, 0, 5, 8'h00, 0, 8'h00, 3'd1, 0, "R2 output disable");
    step(0, 1, 0, 0, 0, 5, 8'h00, 0, 8'h00, 3'd1, 0, "R2 disable strobe low");
    step(0, 0, 0, 1, 0, 5, 8'h00, 0, 8'h00, 3'd1, 0, "R11 vpp all low");
    step(0, 0, 1, 0, 1, 2, 8'h00, 1, 8'h1C, 3'd6, 1, "R6 manufacturer byte");
    step(0, 0, 1, 0, 1, 3, 8'h00, 1, 8'h01, 3'd6, 1, "R6 device byte");
    step(0, 0, 1, 0, 1, 0, 8'h00, 1, 8'h7F, 3'd6, 1, "R7 continuation a0 low");
    step(0, 0, 1, 0, 1, 1, 8'h00, 1, 8'h7F, 3'd6, 1, "R7 continuation a0 high");
    step(1, 1, 1, 0, 0, 0, 8'h00, 0, 8'h00, 3'd0, 0, "R3 idle");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule